// File: doc/BRIEF.md
# TDM Serial Receiver with Sync Tracking

This block turns one time-division-multiplexed serial data line into parallel channel words. The external bit clock reaches it as two single-cycle strobes in the system clock domain, one for each of its rising and falling edges. A frame sync marks where each frame starts. The sync and both strobes come either from the receiver's own pins or, in shared mode, from the pins of a paired transmitter.

Run-time inputs set the frame shape and the line conventions:

- slot count and slot width (8 or 16 bits);
- sync length and active level;
- which clock edge samples the sync, and which edge samples the data;
- a delay of 0 to 3 bit clocks between the sync and the first data bit;
- bit order;
- a per-slot enable mask.

Each completed word from an enabled slot is presented for one cycle, tagged with its slot number. A two-bit lock code follows the sync history: 0 means no sync has been seen, 1 means one sync has been seen, and 2 means a second sync arrived at the expected spacing. Software is expected to wait for code 2 before it enables slots. Separate one-cycle pulses report a word the consumer did not accept and a sync at the wrong bit position.

Top module: `tdm_rx`

## Requirements
- R1: Sync is sampled on the bit-clock edge chosen by `cfg_sync_fall`, and data on the edge chosen by `cfg_data_fall` (1 = falling, 0 = rising). A sync seen on the same strobe as a data sample aligns that sample. Otherwise it aligns the next data sample.
- R2: With delay d = `cfg_delay`, the aligned sample is frame bit (frame_bits − d) of the previous frame, and bit 0 of the new frame arrives d data samples later. For d = 0 the aligned sample is bit 0 itself.
- R3: A frame holds `cfg_last_slot`+1 slots, numbered from 0 in time order. Each slot is 16 bits wide when `cfg_wide`=1 and 8 bits wide otherwise. An 8-bit word appears in `word_data[7:0]` with bits 15:8 at zero.
- R4: With `cfg_lsb_first`=0, the first bit received in a slot is the word's MSB. With `cfg_lsb_first`=1, it is bit 0.
- R5: The sync is active high, or active low when `cfg_sync_low`=1. With `cfg_sync_word`=0 (one-bit sync), every sync sample at the active level is a sync event. With `cfg_sync_word`=1 (slot-long sync), only a change from inactive to active is a sync event.
- R6: With `cfg_shared`=1, the bit-clock strobes and sync come from `tx_clk_rise`, `tx_clk_fall` and `tx_sync`, and the receive strobes and `rx_sync` have no effect. Data always comes from `rx_data`.
- R7: A word is produced only for slot i with `cfg_slot_en[i]`=1.
- R8: `lock_state` is 0 after reset, becomes 1 at the first sync event, and becomes 2 when a later sync lands at the expected frame position. No word is produced before the first sync.
- R9: When the lock code is nonzero, a sync at any other bit position gives a one-cycle `sync_err_evt` pulse and sets the lock code to 1. It also realigns the bit and slot counters to the sync, and the partial word that was being assembled is not produced.
- R10: `word_valid` is high for exactly one cycle per word, with `word_data` and `word_slot` valid in that cycle.
- R11: A cycle with `word_valid`=1 and `word_ready`=0 is followed by a one-cycle `overrun_evt` pulse.
- R12: After reset, `word_valid`, `overrun_evt` and `sync_err_evt` are 0 and `lock_state` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shared | input | 1 | Use the transmitter's strobes and sync |
| rx_clk_rise | input | 1 | Receive bit clock rising-edge strobe |
| rx_clk_fall | input | 1 | Receive bit clock falling-edge strobe |
| rx_sync | input | 1 | Receive frame sync level |
| tx_clk_rise | input | 1 | Transmit bit clock rising-edge strobe |
| tx_clk_fall | input | 1 | Transmit bit clock falling-edge strobe |
| tx_sync | input | 1 | Transmit frame sync level |
| rx_data | input | 1 | Serial data line |
| cfg_last_slot | input | SLOT_W | Slots per frame minus one |
| cfg_wide | input | 1 | 1 = 16-bit slots, 0 = 8-bit slots |
| cfg_sync_word | input | 1 | 1 = slot-long sync, 0 = one-bit sync |
| cfg_sync_low | input | 1 | Sync is active low |
| cfg_sync_fall | input | 1 | Sample the sync on the falling edge |
| cfg_data_fall | input | 1 | Sample the data on the falling edge |
| cfg_delay | input | 2 | Sync-to-first-bit delay in bit clocks |
| cfg_lsb_first | input | 1 | Bit order within a slot |
| cfg_slot_en | input | MAX_SLOTS | Per-slot capture enable |
| word_ready | input | 1 | Consumer accepts the word |
| word_valid | output | 1 | Word presented this cycle |
| word_data | output | WORD_W | Received word |
| word_slot | output | SLOT_W | Slot number of the word |
| lock_state | output | 2 | 0 idle, 1 first sync, 2 locked |
| overrun_evt | output | 1 | Previous word was not accepted |
| sync_err_evt | output | 1 | Sync arrived at the wrong position |

## Verification
A wrong bit or slot counter shows up at the ports as shifted or bit-reversed words, or as words tagged with the wrong slot. It becomes visible no later than the end of the first slot after alignment, and the lock code fails to reach 2 at the second sync. A wrong delay or wrong edge alignment produces words that are off by one or more bit positions from the very first frame, and a steady run of sync errors. A wrong lock or error state shows up as a lock code that is missing or out of order, or as a sync-error pulse on a clean stream, within one frame.

// File: rtl/tdm_rx_pkg.sv
// Shared types for the TDM receiver.
package tdm_rx_pkg;

    // Sync tracking code driven onto the lock_state port.
    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_FIRST  = 2'd1,
        LK_LOCKED = 2'd2
    } lock_e;

endpackage

// File: rtl/tdm_rx_strobe.sv
// tdm_rx_strobe: selects the clock/sync source (own or shared), picks the
// sampling edge for sync and data, and turns sync samples into a sync hit
// aligned to a data sample.
// Assumes the rise and fall strobes are single-cycle and never both high.
module tdm_rx_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_shared,
    input  logic rx_clk_rise,
    input  logic rx_clk_fall,
    input  logic rx_sync,
    input  logic tx_clk_rise,
    input  logic tx_clk_fall,
    input  logic tx_sync,
    input  logic cfg_sync_word,
    input  logic cfg_sync_low,
    input  logic cfg_sync_fall,
    input  logic cfg_data_fall,
    output logic data_stb,
    output logic sync_hit
);
    logic rise_s, fall_s, sync_lvl;
    logic sync_stb, sync_act, sync_det;
    logic prev_act, pending;

    // Pick the strobe and sync source, then the edges used for sampling.
    always_comb begin
        rise_s   = cfg_shared ? tx_clk_rise : rx_clk_rise;
        fall_s   = cfg_shared ? tx_clk_fall : rx_clk_fall;
        sync_lvl = cfg_shared ? tx_sync     : rx_sync;
        sync_stb = cfg_sync_fall ? fall_s : rise_s;
        data_stb = cfg_data_fall ? fall_s : rise_s;
        sync_act = sync_lvl ^ cfg_sync_low;
        sync_det = sync_stb & sync_act & (~cfg_sync_word | ~prev_act);
        sync_hit = data_stb & (sync_det | pending);
    end

    // Remember the previous sampled sync level for leading-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_act <= 1'b0;
        else if (sync_stb) prev_act <= sync_act;
    end

    // Hold a sync seen between data samples until the next data sample.
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (data_stb) pending <= 1'b0;
        else if (sync_det) pending <= 1'b1;
    end
endmodule

// File: rtl/tdm_rx_framer.sv
// tdm_rx_framer: tracks the bit and slot position of each data sample,
// checks syncs against the expected frame boundary, keeps the lock code and
// reports misplaced syncs. Assumes cfg_* are stable while receiving.
module tdm_rx_framer
    import tdm_rx_pkg::*;
#(
    parameter int SLOT_W = 3,
    parameter int BIT_W  = 4,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_stb,
    input  logic              sync_hit,
    input  logic [SLOT_W-1:0] cfg_last_slot,
    input  logic              cfg_wide,
    input  logic [1:0]        cfg_delay,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [BIT_W-1:0]  cur_bit,
    output logic [BIT_W-1:0]  last_bit,
    output logic              word_ok,
    output lock_e             lock_q,
    output logic              sync_err_evt
);
    logic [SLOT_W-1:0] pos_slot, exp_slot, nxt_slot;
    logic [BIT_W-1:0]  pos_bit, exp_bit, nxt_bit;
    logic              good_q, match, realign, err;

    // Expected position of the sync-aligned sample and the current sample.
    always_comb begin
        last_bit = cfg_wide ? BIT_W'(WORD_W - 1) : BIT_W'(WORD_W / 2 - 1);
        exp_slot = (cfg_delay == 2'd0) ? '0 : cfg_last_slot;
        exp_bit  = (cfg_delay == 2'd0) ? '0
                 : BIT_W'(last_bit - BIT_W'(cfg_delay) + BIT_W'(1));
        match    = (pos_slot == exp_slot) && (pos_bit == exp_bit);
        realign  = sync_hit && ((lock_q == LK_IDLE) || !match);
        err      = sync_hit && (lock_q != LK_IDLE) && !match;
        cur_slot = realign ? exp_slot : pos_slot;
        cur_bit  = realign ? exp_bit  : pos_bit;
        word_ok  = realign ? (cur_bit == '0)
                 : ((good_q || cur_bit == '0) && lock_q != LK_IDLE);
    end

    // Position of the sample after the current one.
    always_comb begin
        if (cur_bit >= last_bit) begin
            nxt_bit  = '0;
            nxt_slot = (cur_slot >= cfg_last_slot) ? '0 : SLOT_W'(cur_slot + 1'b1);
        end else begin
            nxt_bit  = BIT_W'(cur_bit + 1'b1);
            nxt_slot = cur_slot;
        end
    end

    // Advance the bit and slot counters on each data sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_slot <= '0;
            pos_bit  <= '0;
            good_q   <= 1'b0;
        end else if (data_stb) begin
            pos_slot <= nxt_slot;
            pos_bit  <= nxt_bit;
            good_q   <= word_ok;
        end
    end

    // Lock code: first sync, then locked on a correctly placed sync.
    always_ff @(posedge clk) begin
        if (!rst_n)                                lock_q <= LK_IDLE;
        else if (realign)                          lock_q <= LK_FIRST;
        else if (sync_hit && lock_q == LK_FIRST)   lock_q <= LK_LOCKED;
    end

    // One-cycle pulse for a sync at the wrong bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_err_evt <= 1'b0;
        else        sync_err_evt <= err;
    end
endmodule

// File: rtl/tdm_rx_assembler.sv
// tdm_rx_assembler: collects data bits into a word in the chosen bit order
// and presents finished words of enabled slots for one cycle; flags words
// the consumer did not accept. Assumes one data sample per strobe.
module tdm_rx_assembler #(
    parameter int MAX_SLOTS = 8,
    parameter int SLOT_W    = 3,
    parameter int BIT_W     = 4,
    parameter int WORD_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_stb,
    input  logic                 data_bit,
    input  logic [SLOT_W-1:0]    cur_slot,
    input  logic [BIT_W-1:0]     cur_bit,
    input  logic [BIT_W-1:0]     last_bit,
    input  logic                 word_ok,
    input  logic                 cfg_lsb_first,
    input  logic [MAX_SLOTS-1:0] cfg_slot_en,
    input  logic                 word_ready,
    output logic                 word_valid,
    output logic [WORD_W-1:0]    word_data,
    output logic [SLOT_W-1:0]    word_slot,
    output logic                 overrun_evt
);
    logic [WORD_W-1:0] acc_q, acc_d;
    logic [BIT_W-1:0]  idx;
    logic              emit;

    // Place the current bit into the word being assembled.
    always_comb begin
        idx   = cfg_lsb_first ? cur_bit : BIT_W'(last_bit - cur_bit);
        acc_d = (cur_bit == '0) ? '0 : acc_q;
        acc_d[idx] = data_bit;
        emit  = data_stb && (cur_bit == last_bit) && word_ok
             && cfg_slot_en[cur_slot];
    end

    // Word accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (data_stb) acc_q <= acc_d;
    end

    // Present the finished word with its slot number for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
            word_slot  <= '0;
        end else begin
            word_valid <= emit;
            if (emit) begin
                word_data <= acc_d;
                word_slot <= cur_slot;
            end
        end
    end

    // Flag a presented word that the consumer did not take.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun_evt <= 1'b0;
        else        overrun_evt <= word_valid & ~word_ready;
    end
endmodule

// File: rtl/tdm_rx.sv
// tdm_rx: TDM serial receiver top. Strobe selection, frame tracking and
// word assembly are chained; all configuration is taken from run-time ports.
// Assumes bit-clock strobes are already synchronous to clk.
module tdm_rx
    import tdm_rx_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    parameter int WORD_W    = 16,
    localparam int SLOT_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_shared,
    input  logic                 rx_clk_rise,
    input  logic                 rx_clk_fall,
    input  logic                 rx_sync,
    input  logic                 tx_clk_rise,
    input  logic                 tx_clk_fall,
    input  logic                 tx_sync,
    input  logic                 rx_data,
    input  logic [SLOT_W-1:0]    cfg_last_slot,
    input  logic                 cfg_wide,
    input  logic                 cfg_sync_word,
    input  logic                 cfg_sync_low,
    input  logic                 cfg_sync_fall,
    input  logic                 cfg_data_fall,
    input  logic [1:0]           cfg_delay,
    input  logic                 cfg_lsb_first,
    input  logic [MAX_SLOTS-1:0] cfg_slot_en,
    input  logic                 word_ready,
    output logic                 word_valid,
    output logic [WORD_W-1:0]    word_data,
    output logic [SLOT_W-1:0]    word_slot,
    output logic [1:0]           lock_state,
    output logic                 overrun_evt,
    output logic                 sync_err_evt
);
    logic              data_stb, sync_hit, word_ok;
    logic [SLOT_W-1:0] cur_slot;
    logic [BIT_W-1:0]  cur_bit, last_bit;
    lock_e             lock_q;

    tdm_rx_strobe u_strobe (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_shared    (cfg_shared),
        .rx_clk_rise   (rx_clk_rise),
        .rx_clk_fall   (rx_clk_fall),
        .rx_sync       (rx_sync),
        .tx_clk_rise   (tx_clk_rise),
        .tx_clk_fall   (tx_clk_fall),
        .tx_sync       (tx_sync),
        .cfg_sync_word (cfg_sync_word),
        .cfg_sync_low  (cfg_sync_low),
        .cfg_sync_fall (cfg_sync_fall),
        .cfg_data_fall (cfg_data_fall),
        .data_stb      (data_stb),
        .sync_hit      (sync_hit)
    );

    tdm_rx_framer #(.SLOT_W(SLOT_W), .BIT_W(BIT_W), .WORD_W(WORD_W)) u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .data_stb      (data_stb),
        .sync_hit      (sync_hit),
        .cfg_last_slot (cfg_last_slot),
        .cfg_wide      (cfg_wide),
        .cfg_delay     (cfg_delay),
        .cur_slot      (cur_slot),
        .cur_bit       (cur_bit),
        .last_bit      (last_bit),
        .word_ok       (word_ok),
        .lock_q        (lock_q),
        .sync_err_evt  (sync_err_evt)
    );

    tdm_rx_assembler #(
        .MAX_SLOTS (MAX_SLOTS),
        .SLOT_W    (SLOT_W),
        .BIT_W     (BIT_W),
        .WORD_W    (WORD_W)
    ) u_asm (
        .clk           (clk),
        .rst_n         (rst_n),
        .data_stb      (data_stb),
        .data_bit      (rx_data),
        .cur_slot      (cur_slot),
        .cur_bit       (cur_bit),
        .last_bit      (last_bit),
        .word_ok       (word_ok),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_slot_en   (cfg_slot_en),
        .word_ready    (word_ready),
        .word_valid    (word_valid),
        .word_data     (word_data),
        .word_slot     (word_slot),
        .overrun_evt   (overrun_evt)
    );

    // Export the lock code as a plain vector.
    always_comb lock_state = lock_q;
endmodule

// File: rtl/tdm_rx_chk.sv
// tdm_rx_chk: port-level properties of the TDM receiver, bound to tdm_rx.
// Assumes configuration is held stable while out of reset.
module tdm_rx_chk #(
    parameter int MAX_SLOTS = 8,
    parameter int WORD_W    = 16,
    parameter int SLOT_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wide,
    input logic [SLOT_W-1:0]    cfg_last_slot,
    input logic [MAX_SLOTS-1:0] cfg_slot_en,
    input logic                 word_ready,
    input logic                 word_valid,
    input logic [WORD_W-1:0]    word_data,
    input logic [SLOT_W-1:0]    word_slot,
    input logic [1:0]           lock_state,
    input logic                 overrun_evt,
    input logic                 sync_err_evt
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);                                            // R10
    AST_SLOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> cfg_slot_en[word_slot]);                                 // R7
    AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> word_slot <= cfg_last_slot);                             // R3
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !cfg_wide) |-> word_data[WORD_W-1:WORD_W/2] == '0);      // R3
    AST_OVERRUN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> overrun_evt);                           // R11
    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> !overrun_evt);                           // R11
    AST_LOCK_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state != 2'd3);                                                    // R8
    AST_NO_SKIP_TO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state == 2'd0 |=> lock_state != 2'd2);                             // R8
    AST_ERR_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_evt |-> lock_state == 2'd1);                                   // R9
    AST_NO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> lock_state != 2'd0);                                     // R8
endmodule

bind tdm_rx tdm_rx_chk #(.MAX_SLOTS(MAX_SLOTS), .WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wide      (cfg_wide),
    .cfg_last_slot (cfg_last_slot),
    .cfg_slot_en   (cfg_slot_en),
    .word_ready    (word_ready),
    .word_valid    (word_valid),
    .word_data     (word_data),
    .word_slot     (word_slot),
    .lock_state    (lock_state),
    .overrun_evt   (overrun_evt),
    .sync_err_evt  (sync_err_evt)
);

// File: tb/tdm_rx_bench.sv
// Bench for tdm_rx: builds serial frames from random words, drives them
// bit clock by bit clock, and compares received words with the built ones.
module tdm_rx_bench;
    localparam int MAX_SLOTS = 8;
    localparam int WORD_W    = 16;
    localparam int SLOT_W    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_shared = 0, rx_clk_rise = 0, rx_clk_fall = 0, rx_sync = 0;
    logic tx_clk_rise = 0, tx_clk_fall = 0, tx_sync = 0, rx_data = 0;
    logic [SLOT_W-1:0] cfg_last_slot = '0;
    logic cfg_wide = 0, cfg_sync_word = 0, cfg_sync_low = 0;
    logic cfg_sync_fall = 0, cfg_data_fall = 0, cfg_lsb_first = 0;
    logic [1:0] cfg_delay = '0;
    logic [MAX_SLOTS-1:0] cfg_slot_en = '1;
    logic word_ready = 1;
    logic word_valid, overrun_evt, sync_err_evt;
    logic [WORD_W-1:0] word_data;
    logic [SLOT_W-1:0] word_slot;
    logic [1:0] lock_state;

    always #5 clk = ~clk;

    tdm_rx #(.MAX_SLOTS(MAX_SLOTS), .WORD_W(WORD_W)) u_tdm_rx (.*);

    int checks = 0, failures = 0;
    int cyc = 0;
    bit done = 0;

    logic sb [0:1023];
    logic db [0:1023];
    int   slen_len;
    logic [15:0] exp_data [0:63];
    int          exp_slot [0:63];
    int          n_exp;
    logic [15:0] cap_data [0:63];
    int          cap_slot [0:63];
    int          n_cap, ovr_cnt, err_cnt, dbl_cnt;
    logic        last_valid;

    // Capture outputs away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            last_valid = 0;
        end else begin
            if (word_valid && n_cap < 64) begin
                cap_data[n_cap] = word_data;
                cap_slot[n_cap] = int'(word_slot);
                n_cap++;
            end
            if (word_valid && last_valid) dbl_cnt++;
            if (overrun_evt)  ovr_cnt++;
            if (sync_err_evt) err_cnt++;
            last_valid = word_valid;
        end
    end

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: run hung at cycle %0d (expected completion)", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        rx_clk_rise = 0; rx_clk_fall = 0; tx_clk_rise = 0; tx_clk_fall = 0;
        rx_sync = cfg_sync_low; tx_sync = cfg_sync_low; rx_data = 0;
        n_cap = 0; ovr_cnt = 0; err_cnt = 0; dbl_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // One bit clock: rise strobe, gap, fall strobe, gap.
    task automatic drive_period(input logic act, input logic d);
        logic lvl;
        lvl = act ^ cfg_sync_low;
        @(negedge clk);
        rx_data = d;
        if (cfg_shared) begin
            tx_sync = lvl; rx_sync = 1'($urandom() % 2); tx_clk_rise = 1;
        end else begin
            rx_sync = lvl; rx_clk_rise = 1;
        end
        @(negedge clk);
        tx_clk_rise = 0;
        rx_clk_rise = cfg_shared;
        @(negedge clk);
        rx_clk_rise = 0;
        if (cfg_shared) tx_clk_fall = 1; else rx_clk_fall = 1;
        @(negedge clk);
        tx_clk_fall = 0;
        rx_clk_fall = cfg_shared;
        if (cfg_shared) rx_sync = 1'($urandom() % 2);
    endtask

    task automatic idle_periods(input int n);
        for (int i = 0; i < n; i++) drive_period(1'b0, 1'($urandom() % 2));
        @(negedge clk);
        rx_clk_fall = 0;
    endtask

    // Build a stream of nframes frames; slen = active sync periods per frame.
    task automatic build(input int nframes, input int slen);
        int w, s, fb, off, lead, base, sp;
        logic [15:0] word, mask;
        w    = cfg_wide ? 16 : 8;
        s    = int'(cfg_last_slot) + 1;
        fb   = w * s;
        off  = (cfg_sync_fall && !cfg_data_fall) ? 1 : 0;
        lead = 5 + int'($urandom() % 4);
        base = lead + off + int'(cfg_delay);
        slen_len = base + nframes * fb;
        mask = cfg_wide ? 16'hFFFF : 16'h00FF;
        n_exp = 0;
        for (int i = 0; i < slen_len; i++) begin
            db[i] = 1'($urandom() % 2);
            sb[i] = 1'b0;
        end
        for (int f = 0; f < nframes; f++) begin
            sp = lead + f * fb;
            for (int k = 0; k < slen; k++) sb[sp + k] = 1'b1;
            for (int sl = 0; sl < s; sl++) begin
                word = 16'($urandom()) & mask;
                for (int b = 0; b < w; b++)
                    db[base + f * fb + sl * w + b] = cfg_lsb_first ? word[b] : word[w - 1 - b];
                if (cfg_slot_en[sl]) begin
                    exp_data[n_exp] = word;
                    exp_slot[n_exp] = sl;
                    n_exp++;
                end
            end
        end
    endtask

    function automatic int sync_len();
        int w;
        w = cfg_wide ? 16 : 8;
        if (!cfg_sync_word) return 1;
        return (cfg_last_slot == '0) ? w / 2 : w;
    endfunction

    task automatic play();
        for (int i = 0; i < slen_len; i++) drive_period(sb[i], db[i]);
        idle_periods(2);
        repeat (4) @(negedge clk);
    endtask

    task automatic compare_words(input string req);
        check(n_cap == n_exp, {req, " word count"}, n_cap, n_exp);
        for (int i = 0; i < n_exp && i < n_cap; i++) begin
            check(cap_data[i] == exp_data[i], {req, " word data"}, cap_data[i], exp_data[i]);
            check(cap_slot[i] == exp_slot[i], {req, " word slot"}, cap_slot[i], exp_slot[i]);
        end
    endtask

    task automatic run_case(input int nframes, input string req);
        do_reset();
        build(nframes, sync_len());
        play();
        compare_words(req);
        check(err_cnt == 0, {req, " no sync error"}, err_cnt, 0);
        check(dbl_cnt == 0, "R10 one-cycle valid", dbl_cnt, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // R12: reset state
        do_reset();
        @(negedge clk);
        check(word_valid == 0 && overrun_evt == 0 && sync_err_evt == 0, "R12 outputs idle",
              {word_valid, overrun_evt, sync_err_evt}, 0);
        check(lock_state == 2'd0, "R12 lock idle", lock_state, 0);

        // R1 R2 R4 R8: one 16-bit slot, one-bit sync on falling edge, data on rising, delay 1
        cfg_last_slot = 0; cfg_wide = 1; cfg_sync_word = 0; cfg_sync_low = 0;
        cfg_sync_fall = 1; cfg_data_fall = 0; cfg_delay = 1; cfg_lsb_first = 0;
        cfg_slot_en = '1; cfg_shared = 0;
        run_case(3, "R1 R2 R4");
        check(lock_state == 2'd2, "R8 locked after second sync", lock_state, 2);

        // R9: misplaced sync after lock
        idle_periods(3);
        drive_period(1'b1, 1'b0);
        idle_periods(2);
        repeat (4) @(negedge clk);
        check(err_cnt == 1, "R9 sync error pulse", err_cnt, 1);
        check(lock_state == 2'd1, "R9 lock drops to first", lock_state, 1);
        check(n_cap == n_exp, "R9 partial word dropped", n_cap, n_exp);

        // R5: two 16-bit slots, slot-long active-low sync, delay 0
        cfg_last_slot = 1; cfg_wide = 1; cfg_sync_word = 1; cfg_sync_low = 1;
        cfg_sync_fall = 0; cfg_data_fall = 0; cfg_delay = 0; cfg_lsb_first = 0;
        run_case(3, "R5 slot-long low sync");
        check(lock_state == 2'd2, "R5 locks", lock_state, 2);

        // R5: one-bit sync held for two bit clocks gives sync errors
        cfg_sync_word = 0; cfg_sync_low = 0;
        do_reset();
        build(3, 2);
        play();
        check(err_cnt > 0, "R5 held one-bit sync counts twice", err_cnt, 1);
        check(lock_state != 2'd2, "R5 no lock on doubled sync", lock_state, 1);

        // R8: one frame only leaves the code at first-sync
        cfg_last_slot = 2; cfg_wide = 0; cfg_delay = 2; cfg_lsb_first = 1;
        cfg_sync_fall = 0; cfg_data_fall = 1;
        run_case(1, "R8 single frame");
        check(lock_state == 2'd1, "R8 first sync only", lock_state, 1);

        // R7: all slots disabled gives no words
        cfg_slot_en = '0;
        run_case(2, "R7 slots disabled");

        // R11: consumer not ready
        cfg_slot_en = 8'b0000_0101; cfg_last_slot = 3; cfg_delay = 3;
        word_ready = 0;
        run_case(2, "R11 words while stalled");
        check(ovr_cnt == n_exp, "R11 overrun per word", ovr_cnt, n_exp);
        word_ready = 1;

        // R6: shared mode with junk on receive strobes and sync
        cfg_shared = 1; cfg_slot_en = '1; cfg_delay = 1; cfg_wide = 1;
        cfg_sync_fall = 1; cfg_data_fall = 0;
        run_case(3, "R6 shared source");
        check(lock_state == 2'd2, "R6 shared locks", lock_state, 2);

        // R3 R1 R2 R4 R5 R6 R7: random configurations
        for (int t = 0; t < 10; t++) begin
            cfg_shared    = 1'($urandom() % 2);
            cfg_last_slot = SLOT_W'($urandom() % MAX_SLOTS);
            cfg_wide      = 1'($urandom() % 2);
            cfg_sync_word = 1'($urandom() % 2);
            cfg_sync_low  = 1'($urandom() % 2);
            cfg_sync_fall = 1'($urandom() % 2);
            cfg_data_fall = 1'($urandom() % 2);
            cfg_delay     = 2'($urandom() % 4);
            cfg_lsb_first = 1'($urandom() % 2);
            cfg_slot_en   = MAX_SLOTS'($urandom());
            run_case(3, "R3 random frame");
            check(lock_state == 2'd2, "R8 random lock", lock_state, 2);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule